// File: doc/BRIEF.md
# Downstream Message Receive Dispatcher

This block sits behind the receive side of a multi-function endpoint and takes one already-decoded downstream message per cycle. Each message arrives as a code, a routing field, the 64-bit address field and a target function number. The block works out which functions the message reaches and applies a fixed default policy for each message type. The result is a single-cycle verdict: handled, or Completer Abort.

Broadcast and terminate-at-receiver messages reach every function. ID-routed messages are matched against the device's own bus/device number in the top 16 bits of the address field. All other routes go to the function number supplied with the message.

Some message types are passed to handlers through per-type strobes: the ATS/PRS group and a set of general types. Message codes that are not recognised are reported on an unknown-type path together with their raw code. A power-down request produces an acknowledge request towards the upstream transmitter. That request is held until it is taken. Further requests that arrive meanwhile are counted in a small queue, and the input back-pressures when the queue is full.

The message input is valid/ready. A message is taken in any cycle where `in_valid` and `in_ready` are both high. `in_ready` falls only when the acknowledge queue is full. Results carry no back-pressure. The acknowledge output is valid/ready: `ack_valid` stays high and `ack_dev_id` stays stable until `ack_ready` is seen.

Top module: `msgd_dispatch`

## Requirements
- R1: A message is accepted in a cycle where in_valid and in_ready are both high. Exactly one cycle later res_valid pulses high for one cycle, with res_abort and the delivery and strobe outputs for that message. With no acceptance, res_valid, ats_stb, hnd_stb and unk_valid stay low in the next cycle.
- R2: Routing value 3'b011 (broadcast) or 3'b100 (terminate at receiver) sets all NUM_FUNC bits of fn_mask, whatever in_func holds.
- R3: Routing value 3'b010 (by ID) delivers to function addr[50:48], and only when addr[63:51] equals self_busdev and that function is below NUM_FUNC. Every other routing value delivers to in_func, and only when in_func is below NUM_FUNC. A failed delivery gives res_abort=1 and fn_mask=0, with no strobe, no unknown report and no acknowledge.
- R4: Codes 8'h01 (ATS invalidate), 8'h04 (page request) and 8'h05 (page response) pulse ats_stb bit 0, 1 or 2 respectively and are handled when ats_present is high. When ats_present is low they abort with no strobe.
- R5: Code 8'h7F (vendor type 1) is always handled. hnd_stb[4] pulses only when hnd_en[4] is high.
- R6: Codes 8'h40 through 8'h48 (hot plug) are always handled. hnd_stb[5] pulses only when hnd_en[5] is high.
- R7: Codes 8'h14 (ASPM NAK), 8'h00 (unlock), 8'h50 (slot power limit) and 8'h7E (vendor type 0) use bits 0, 1, 2 and 3 of hnd_en and hnd_stb respectively. Each is handled with a strobe when its enable is high and aborts with no strobe otherwise.
- R8: Any other code pulses unk_valid with unk_code equal to the raw code. It is handled when unk_en is high and aborts otherwise.
- R9: A delivered code 8'h19 (power-down request) is handled and queues one acknowledge. ack_valid is high from the cycle after acceptance, and ack_dev_id equals {self_busdev, 3'b000}.
- R10: Each cycle with ack_valid and ack_ready both high retires one acknowledge. Up to ACK_DEPTH acknowledges wait, and none is dropped. in_ready is low exactly while ACK_DEPTH acknowledges wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Message present |
| in_ready | output | 1 | Dispatcher can accept |
| in_code | input | 8 | Message code |
| in_route | input | 3 | Routing field |
| in_addr | input | 64 | Message address field, Device ID in 63:48 |
| in_func | input | 3 | Target function for non-ID routes |
| self_busdev | input | 13 | This device's bus and device number |
| ats_present | input | 1 | ATS/PRS handler present |
| hnd_en | input | 6 | Per-type handler enables |
| unk_en | input | 1 | Unknown-type handler enable |
| res_valid | output | 1 | Result pulse |
| res_abort | output | 1 | Completer Abort for this message |
| fn_mask | output | NUM_FUNC | Functions that received the message |
| ats_stb | output | 3 | ATS/PRS handler strobes |
| hnd_stb | output | 6 | Per-type handler strobes |
| unk_valid | output | 1 | Unknown code reported |
| unk_code | output | 8 | Raw unknown code |
| ack_valid | output | 1 | Acknowledge request pending |
| ack_ready | input | 1 | Upstream transmitter takes acknowledge |
| ack_dev_id | output | 16 | Device ID carried by the acknowledge |

## Verification
Every per-message result (verdict, fn_mask, strobes, unknown report) is registered once. It is therefore due exactly one cycle after the acceptance edge, and the bench samples it on the falling edge that follows that rising edge. in_ready and ack_valid depend only on the queue count. The bench compares them on the falling edge before each rising edge against a modelled count, which it updates from the pushes and pops of that edge. This means a new acknowledge is first expected one cycle after its request is accepted.

// File: rtl/msgd_pkg.sv
package msgd_pkg;
  localparam logic [7:0] C_UNLOCK   = 8'h00;
  localparam logic [7:0] C_ATS_INV  = 8'h01;
  localparam logic [7:0] C_PRS_REQ  = 8'h04;
  localparam logic [7:0] C_PRS_RSP  = 8'h05;
  localparam logic [7:0] C_PM_NAK   = 8'h14;
  localparam logic [7:0] C_TURN_OFF = 8'h19;
  localparam logic [7:0] C_SLOT_PWR = 8'h50;
  localparam logic [7:0] C_VDM0     = 8'h7E;
  localparam logic [7:0] C_VDM1     = 8'h7F;
  localparam logic [7:0] C_HP_LO    = 8'h40;
  localparam logic [7:0] C_HP_HI    = 8'h48;

  localparam logic [2:0] RT_ID    = 3'b010;
  localparam logic [2:0] RT_BCAST = 3'b011;
  localparam logic [2:0] RT_LOCAL = 3'b100;

  localparam int HND_N   = 6;
  localparam int H_PMNAK = 0;
  localparam int H_UNLK  = 1;
  localparam int H_SLOT  = 2;
  localparam int H_VDM0  = 3;
  localparam int H_VDM1  = 4;
  localparam int H_HPLG  = 5;
  localparam int ATS_N   = 3;

  typedef enum logic [3:0] {
    K_UNKNOWN, K_UNLOCK, K_ATS_INV, K_PRS_REQ, K_PRS_RSP, K_PM_NAK,
    K_TURN_OFF, K_SLOT_PWR, K_VDM0, K_VDM1, K_HOTPLUG
  } msg_kind_e;

  typedef struct packed {
    logic              abort;
    logic [ATS_N-1:0]  ats;
    logic [HND_N-1:0]  hnd;
    logic              unk;
    logic              ack_push;
  } verdict_t;
endpackage

// File: rtl/msgd_classify.sv
module msgd_classify
  import msgd_pkg::*;
(
  input  logic [7:0] code,
  output msg_kind_e  kind
);
  always_comb begin
    kind = K_UNKNOWN;
    if (code >= C_HP_LO && code <= C_HP_HI) begin
      kind = K_HOTPLUG;
    end else begin
      case (code)
        C_UNLOCK:   kind = K_UNLOCK;
        C_ATS_INV:  kind = K_ATS_INV;
        C_PRS_REQ:  kind = K_PRS_REQ;
        C_PRS_RSP:  kind = K_PRS_RSP;
        C_PM_NAK:   kind = K_PM_NAK;
        C_TURN_OFF: kind = K_TURN_OFF;
        C_SLOT_PWR: kind = K_SLOT_PWR;
        C_VDM0:     kind = K_VDM0;
        C_VDM1:     kind = K_VDM1;
        default:    kind = K_UNKNOWN;
      endcase
    end
  end
endmodule

// File: rtl/msgd_fanout.sv
module msgd_fanout
  import msgd_pkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter int FN_W     = 3
) (
  input  logic [2:0]          route,
  input  logic [63:0]         addr,
  input  logic [FN_W-1:0]     func,
  input  logic [12:0]         self_busdev,
  output logic                ok,
  output logic [NUM_FUNC-1:0] mask
);
  logic            to_all;
  logic [FN_W-1:0] sel;

  always_comb begin
    to_all = 1'b0;
    sel    = func;
    ok     = 1'b0;
    case (route)
      RT_BCAST, RT_LOCAL: begin
        to_all = 1'b1;
        ok     = 1'b1;
      end
      RT_ID: begin
        sel = addr[48 +: FN_W];
        ok  = (addr[63:51] == self_busdev) && (int'(sel) < NUM_FUNC);
      end
      default: begin
        ok = int'(func) < NUM_FUNC;
      end
    endcase
  end

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_fn
    assign mask[i] = ok && (to_all || (int'(sel) == i));
  end
endmodule

// File: rtl/msgd_policy.sv
module msgd_policy
  import msgd_pkg::*;
(
  input  msg_kind_e         kind,
  input  logic              deliver_ok,
  input  logic              ats_present,
  input  logic [HND_N-1:0]  hnd_en,
  input  logic              unk_en,
  output verdict_t          verdict
);
  always_comb begin
    verdict = '0;
    if (!deliver_ok) begin
      verdict.abort = 1'b1;
    end else begin
      case (kind)
        K_ATS_INV: begin
          verdict.ats[0] = ats_present;
          verdict.abort  = !ats_present;
        end
        K_PRS_REQ: begin
          verdict.ats[1] = ats_present;
          verdict.abort  = !ats_present;
        end
        K_PRS_RSP: begin
          verdict.ats[2] = ats_present;
          verdict.abort  = !ats_present;
        end
        K_TURN_OFF: verdict.ack_push = 1'b1;
        K_VDM1:     verdict.hnd[H_VDM1] = hnd_en[H_VDM1];
        K_HOTPLUG:  verdict.hnd[H_HPLG] = hnd_en[H_HPLG];
        K_PM_NAK: begin
          verdict.hnd[H_PMNAK] = hnd_en[H_PMNAK];
          verdict.abort        = !hnd_en[H_PMNAK];
        end
        K_UNLOCK: begin
          verdict.hnd[H_UNLK] = hnd_en[H_UNLK];
          verdict.abort       = !hnd_en[H_UNLK];
        end
        K_SLOT_PWR: begin
          verdict.hnd[H_SLOT] = hnd_en[H_SLOT];
          verdict.abort       = !hnd_en[H_SLOT];
        end
        K_VDM0: begin
          verdict.hnd[H_VDM0] = hnd_en[H_VDM0];
          verdict.abort       = !hnd_en[H_VDM0];
        end
        default: begin
          verdict.unk   = 1'b1;
          verdict.abort = !unk_en;
        end
      endcase
    end
  end
endmodule

// File: rtl/msgd_ack_queue.sv
module msgd_ack_queue #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop_ready,
  output logic pend,
  output logic space
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt;
  logic             pop;

  assign pend  = cnt != '0;
  assign space = cnt < FULL;
  assign pop   = pend && pop_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (push && !pop) cnt <= cnt + 1'b1;
    else if (pop && !push) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/msgd_dispatch.sv
module msgd_dispatch
  import msgd_pkg::*;
#(
  parameter int NUM_FUNC  = 4,
  parameter int ACK_DEPTH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_code,
  input  logic [2:0]          in_route,
  input  logic [63:0]         in_addr,
  input  logic [2:0]          in_func,
  input  logic [12:0]         self_busdev,
  input  logic                ats_present,
  input  logic [5:0]          hnd_en,
  input  logic                unk_en,
  output logic                res_valid,
  output logic                res_abort,
  output logic [NUM_FUNC-1:0] fn_mask,
  output logic [2:0]          ats_stb,
  output logic [5:0]          hnd_stb,
  output logic                unk_valid,
  output logic [7:0]          unk_code,
  output logic                ack_valid,
  input  logic                ack_ready,
  output logic [15:0]         ack_dev_id
);
  msg_kind_e           kind;
  logic                dlv_ok;
  logic [NUM_FUNC-1:0] dlv_mask;
  verdict_t            vd;
  logic                accept;
  logic                q_space;

  msgd_classify u_cls (.code(in_code), .kind(kind));

  msgd_fanout #(.NUM_FUNC(NUM_FUNC), .FN_W(3)) u_fan (
    .route(in_route), .addr(in_addr), .func(in_func),
    .self_busdev(self_busdev), .ok(dlv_ok), .mask(dlv_mask)
  );

  msgd_policy u_pol (
    .kind(kind), .deliver_ok(dlv_ok), .ats_present(ats_present),
    .hnd_en(hnd_en), .unk_en(unk_en), .verdict(vd)
  );

  assign in_ready = q_space;
  assign accept   = in_valid && q_space;

  msgd_ack_queue #(.DEPTH(ACK_DEPTH)) u_ackq (
    .clk(clk), .rst_n(rst_n), .push(accept && vd.ack_push),
    .pop_ready(ack_ready), .pend(ack_valid), .space(q_space)
  );

  assign ack_dev_id = {self_busdev, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_abort <= 1'b0;
      fn_mask   <= '0;
      ats_stb   <= '0;
      hnd_stb   <= '0;
      unk_valid <= 1'b0;
      unk_code  <= '0;
    end else begin
      res_valid <= accept;
      res_abort <= accept && vd.abort;
      fn_mask   <= accept ? dlv_mask : '0;
      ats_stb   <= accept ? vd.ats : '0;
      hnd_stb   <= accept ? vd.hnd : '0;
      unk_valid <= accept && vd.unk;
      if (accept && vd.unk) unk_code <= in_code;
    end
  end
endmodule

// File: rtl/msgd_dispatch_chk.sv
module msgd_dispatch_chk #(
  parameter int NUM_FUNC = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [7:0]          in_code,
  input logic [2:0]          in_route,
  input logic                res_valid,
  input logic                res_abort,
  input logic [NUM_FUNC-1:0] fn_mask,
  input logic [2:0]          ats_stb,
  input logic [5:0]          hnd_stb,
  input logic                unk_valid,
  input logic                ack_valid,
  input logic                ack_ready,
  input logic [15:0]         ack_dev_id
);
  // R1
  res_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);
  // R1
  no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> (!res_valid && ats_stb == 3'b0 && hnd_stb == 6'b0 && !unk_valid));
  // R2
  bcast_all_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_route == 3'b011 || in_route == 3'b100))
      |=> (fn_mask == {NUM_FUNC{1'b1}}));
  // R3
  undelivered_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && fn_mask == '0) |-> res_abort);
  // R4
  ats_stb_handled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ats_stb != 3'b0) |-> (res_valid && !res_abort && $onehot0(ats_stb)));
  // R9
  turnoff_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_code == 8'h19 && in_route == 3'b011) |=> ack_valid);
  // R10
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_dev_id)));
endmodule

bind msgd_dispatch msgd_dispatch_chk #(.NUM_FUNC(NUM_FUNC)) u_chk (.*);

// File: tb/msgd_dispatch_tb.sv
module msgd_dispatch_tb;
  localparam int NF = 4;
  localparam int DEPTH = 3;
  localparam time CLK_P = 20ns;
  localparam logic [12:0] SELF = 13'h0A5;

  typedef struct packed {
    logic ab; logic [NF-1:0] mk; logic [2:0] at; logic [5:0] hd; logic uk; logic ps;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [7:0] in_code = 0;
  logic [2:0] in_route = 0;
  logic [63:0] in_addr = 0;
  logic [2:0] in_func = 0;
  logic ats_present = 0, unk_en = 0, ack_ready = 0;
  logic [5:0] hnd_en = 0;
  logic res_valid, res_abort, unk_valid, ack_valid;
  logic [NF-1:0] fn_mask;
  logic [2:0] ats_stb;
  logic [5:0] hnd_stb;
  logic [7:0] unk_code;
  logic [15:0] ack_dev_id;

  int n_chk = 0, n_bad = 0, mcnt = 0;

  always #(CLK_P/2) clk = ~clk;

  msgd_dispatch #(.NUM_FUNC(NF), .ACK_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_route(in_route), .in_addr(in_addr), .in_func(in_func),
    .self_busdev(SELF), .ats_present(ats_present), .hnd_en(hnd_en), .unk_en(unk_en),
    .res_valid(res_valid), .res_abort(res_abort), .fn_mask(fn_mask),
    .ats_stb(ats_stb), .hnd_stb(hnd_stb), .unk_valid(unk_valid), .unk_code(unk_code),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_dev_id(ack_dev_id)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t exp_calc(input logic [7:0] c, input logic [2:0] r,
                                    input logic [63:0] a, input logic [2:0] f);
    exp_t e = '0;
    bit ok; int s;
    if (r == 3'b011 || r == 3'b100) begin
      ok = 1; e.mk = '1;
    end else begin
      s  = (r == 3'b010) ? int'(a[50:48]) : int'(f);
      ok = (s < NF) && (r != 3'b010 || a[63:51] == SELF);
      if (ok) e.mk[s] = 1'b1;
    end
    if (!ok) begin e.ab = 1; return e; end
    if (c >= 8'h40 && c <= 8'h48) e.hd[5] = hnd_en[5];
    else case (c)
      8'h01: begin e.at[0] = ats_present; e.ab = !ats_present; end
      8'h04: begin e.at[1] = ats_present; e.ab = !ats_present; end
      8'h05: begin e.at[2] = ats_present; e.ab = !ats_present; end
      8'h19: e.ps = 1;
      8'h7F: e.hd[4] = hnd_en[4];
      8'h14: begin e.hd[0] = hnd_en[0]; e.ab = !hnd_en[0]; end
      8'h00: begin e.hd[1] = hnd_en[1]; e.ab = !hnd_en[1]; end
      8'h50: begin e.hd[2] = hnd_en[2]; e.ab = !hnd_en[2]; end
      8'h7E: begin e.hd[3] = hnd_en[3]; e.ab = !hnd_en[3]; end
      default: begin e.uk = 1; e.ab = !unk_en; end
    endcase
    return e;
  endfunction

  task automatic step(input logic v, input logic [7:0] c, input logic [2:0] r,
                      input logic [63:0] a, input logic [2:0] f, input logic ar);
    exp_t e; bit acc, pop;
    in_valid = v; in_code = c; in_route = r; in_addr = a; in_func = f; ack_ready = ar;
    #1;
    chk(in_ready == (mcnt < DEPTH), "R10 in_ready", 64'(in_ready), 64'(mcnt < DEPTH));
    chk(ack_valid == (mcnt != 0), "R9 ack_valid", 64'(ack_valid), 64'(mcnt != 0));
    if (ack_valid) chk(ack_dev_id == {SELF, 3'b000}, "R9 ack_dev_id", 64'(ack_dev_id), 64'({SELF, 3'b000}));
    acc = v && (mcnt < DEPTH);
    pop = (mcnt != 0) && ar;
    e = exp_calc(c, r, a, f);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk(res_valid == acc, "R1 res_valid", 64'(res_valid), 64'(acc));
    if (acc) begin
      chk(res_abort == e.ab, "R3/R7 res_abort", 64'(res_abort), 64'(e.ab));
      chk(fn_mask == e.mk, "R2/R3 fn_mask", 64'(fn_mask), 64'(e.mk));
      chk(ats_stb == e.at, "R4 ats_stb", 64'(ats_stb), 64'(e.at));
      chk(hnd_stb == e.hd, "R5/R6/R7 hnd_stb", 64'(hnd_stb), 64'(e.hd));
      chk(unk_valid == e.uk, "R8 unk_valid", 64'(unk_valid), 64'(e.uk));
      if (e.uk) chk(unk_code == c, "R8 unk_code", 64'(unk_code), 64'(c));
    end else begin
      chk(ats_stb == 0 && hnd_stb == 0 && !unk_valid, "R1 idle strobes",
          64'({ats_stb, hnd_stb, unk_valid}), 64'(0));
    end
    mcnt = mcnt + int'(acc && e.ps) - int'(pop);
  endtask

  function automatic logic [7:0] pick_code();
    logic [7:0] pool [14] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h14, 8'h19, 8'h50,
                              8'h7E, 8'h7F, 8'h40, 8'h44, 8'h48, 8'h49, 8'h20};
    int k = $urandom_range(0, 15);
    return (k < 14) ? pool[k] : 8'($urandom);
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] a;
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    chk(!res_valid && !ack_valid, "R1 reset outputs", 64'({res_valid, ack_valid}), 64'(0));
    chk(in_ready, "R10 reset ready", 64'(in_ready), 64'(1));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2: broadcast to all functions with out-of-range in_func
    step(1, 8'h7F, 3'b011, 64'h0, 3'd7, 1);
    // R3: ID route mismatch aborts
    step(1, 8'h7F, 3'b010, {16'hFFFF, 48'h0}, 3'd0, 1);
    // R3: ID route match, function 2
    step(1, 8'h7F, 3'b010, {SELF, 3'd2, 48'h0}, 3'd0, 1);
    // R3: in_func out of range on address route
    step(1, 8'h00, 3'b001, 64'h0, 3'd5, 1);
    // R4: ATS absent aborts, present handled
    ats_present = 0; step(1, 8'h04, 3'b100, 64'h0, 3'd0, 1);
    ats_present = 1; step(1, 8'h05, 3'b000, 64'h0, 3'd1, 1);
    // R5/R6: silently accepted without handlers
    hnd_en = 0; step(1, 8'h7F, 3'b000, 64'h0, 3'd0, 1);
    step(1, 8'h48, 3'b000, 64'h0, 3'd0, 1);
    // R7: no handler aborts
    step(1, 8'h14, 3'b100, 64'h0, 3'd0, 1);
    // R8: unknown with no handler
    unk_en = 0; step(1, 8'h20, 3'b000, 64'h0, 3'd3, 1);
    // R9/R10: fill acknowledge queue and push beyond it
    for (int i = 0; i < DEPTH + 2; i++) step(1, 8'h19, 3'b011, 64'h0, 3'd0, 0);
    for (int i = 0; i < DEPTH + 1; i++) step(0, 8'h00, 3'b000, 64'h0, 3'd0, 1);

    for (int i = 0; i < 3000; i++) begin
      if (i % 64 == 0) begin
        hnd_en = 6'($urandom); ats_present = 1'($urandom); unk_en = 1'($urandom);
      end
      a = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0) a[63:51] = SELF;
      step(1'($urandom_range(0, 3) != 0), pick_code(), 3'($urandom), a,
           3'($urandom), 1'($urandom_range(0, 2) == 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule